// File: doc/BRIEF.md
# I2C Target Controller with Sticky Event Flags

This block is the target (slave) side of an I2C link. It watches SCL and SDA through synchronizers, recognises START and STOP, and compares the first byte after each START against a fixed 7-bit own address and against the general call byte 0x00. When the byte matches, the block acknowledges it and then either receives data bytes from the master or shifts out bytes that software placed in its data register. SDA is driven only low, in open-drain fashion, through an output-enable pin.

Software drives the block through a small register port with four byte registers: control, status, interrupt enable and data. A forced-NACK control bit sets the acknowledge level that is returned for received data bytes. It has no say over the acknowledge of the address byte. Five event flags in the status register stay set until software writes a zero to them. A direction flag and a general call flag are kept by hardware. The interrupt output is raised by any enabled event flag.

Top module: `i2c_target_stat`

## Requirements
- R1: After reset every register reads 0x00, SDA is released (`sda_oe`=0) and `irq` is low.
- R2: When the enable bit (control bit 1) is set, an address byte whose upper seven bits equal `OWN_ADDR` is acknowledged by driving SDA low during the ninth clock. It also sets flag bit 0 (address matched) of the status register (address 1).
- R3: An address byte that matches neither `OWN_ADDR` nor the general call byte is not acknowledged. No flag changes, and the STOP that follows sets no flag.
- R4: The address byte 0x00 is acknowledged and sets flag bit 0 and status bit 6 (general call). Bit 6 on its own never raises `irq`.
- R5: Each received data byte can be read at register address 3 and sets status bit 1. Its acknowledge level equals control bit 0 (forced NACK), sampled at the start of the acknowledge clock, so 1 returns a NACK.
- R6: The forced-NACK bit has no effect on the address acknowledge. A matching address is always acknowledged.
- R7: When a read address (R/W bit = 1) matches, status bit 5 is set to 1. It keeps its value until the next address match or until the block is disabled. The byte written to address 3 is shifted out MSB first, and status bit 2 sets every time a byte is loaded for sending.
- R8: A NACK from the master after a sent byte sets status bit 3. The block then releases SDA until the next START.
- R9: A STOP that ends a transfer addressed to this block sets status bit 4. General call (bit 6) clears when bit 4 sets, and clears when the enable bit is 0.
- R10: Status bits 0 to 4 stay at 1 until a write to address 1 carries a 0 in that position. Writing 1 leaves a bit unchanged. Writes do not affect bits 5 to 7, and bit 7 always reads 0.
- R11: `irq` is the OR of status bits 0 to 4, each one gated by the bit in the same position of the interrupt enable register (address 2).
- R12: While the enable bit is 0, the block ignores the bus completely: it gives no acknowledge and sets no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 interrupt enable, 3 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The main function is exercised with four kinds of transfer:
- a write to the own address with the forced-NACK bit first clear and then set, which separates the data acknowledge from the address acknowledge;
- a foreign address, which shows that matching is exact and that a STOP after an unselected transfer sets nothing;
- a general call, which shows that bit 6 is set and later cleared by a STOP and by disabling the block;
- a two-byte read, where the master acknowledges the first byte and refuses the second, which separates the reload path from the end-of-read flag.

Writes of all ones and all zeros to the status register, and interrupt masks that leave only one flag enabled, show which bits are sticky and which bits can raise `irq`.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK
  } tgt_state_t;

  // status bit positions
  localparam int unsigned FLG_ADDR   = 0;
  localparam int unsigned FLG_RXD    = 1;
  localparam int unsigned FLG_TXD    = 2;
  localparam int unsigned FLG_NAK    = 3;
  localparam int unsigned FLG_STOP   = 4;
  localparam int unsigned FLG_DIR    = 5;
  localparam int unsigned FLG_GCALL  = 6;
  localparam int unsigned NUM_STICKY = 5;

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] own);
    return (b[7:1] == own) || (b == 8'h00);
  endfunction

  function automatic logic is_gcall(input logic [7:0] b);
    return b == 8'h00;
  endfunction

  // zero-written bits clear, new events set (set wins)
  function automatic logic [NUM_STICKY-1:0] sticky_next(
    input logic [NUM_STICKY-1:0] cur,
    input logic [NUM_STICKY-1:0] set,
    input logic                  wr,
    input logic [NUM_STICKY-1:0] wmask
  );
    logic [NUM_STICKY-1:0] clr;
    clr = wr ? ~wmask : '0;
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_fold(input logic [NUM_STICKY-1:0] flags,
                                    input logic [NUM_STICKY-1:0] ena);
    return |(flags & ena);
  endfunction

endpackage

// File: rtl/i2ct_linemon.sv
module i2ct_linemon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int unsigned PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_p, sda_p;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[PW-2:0], scl_i};
      sda_p <= {sda_p[PW-2:0], sda_i};
    end
  end

  assign scl_now  = scl_p[SYNC_STAGES-1];
  assign scl_old  = scl_p[SYNC_STAGES];
  assign sda_s    = sda_p[SYNC_STAGES-1];
  assign sda_old  = sda_p[SYNC_STAGES];

  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_ev = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_ev  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       fna,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] tx_byte,
  output logic       sda_oe,
  output logic [7:0] rx_byte,
  output logic       ev_match,
  output logic       ev_gcall,
  output logic       ev_rw,
  output logic       ev_rxdone,
  output logic       ev_txload,
  output logic       ev_nack,
  output logic       ev_stop,
  output logic       aack_drv,
  output logic       rack_drv
);
  tgt_state_t st;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic [7:0] addr_byte;
  logic       ack_on, rw_q, sel, oe;

  assign addr_byte = {sh[6:0], sda_s};

  assign ev_match  = en && st == ST_ADDR && scl_rise && cnt == 3'd7 && addr_hit(addr_byte, OWN_ADDR);
  assign ev_gcall  = ev_match && is_gcall(addr_byte);
  assign ev_rw     = sda_s;
  assign ev_rxdone = en && st == ST_RX && scl_rise && cnt == 3'd7;
  assign ev_txload = en && scl_fall && ack_on &&
                     ((st == ST_AACK && rw_q) || st == ST_TACK);
  assign ev_nack   = en && st == ST_TACK && scl_rise && sda_s;
  assign ev_stop   = en && stop_ev && sel;
  assign aack_drv  = st == ST_AACK && ack_on;
  assign rack_drv  = st == ST_RACK && ack_on;
  assign sda_oe    = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; ack_on <= 1'b0;
      rw_q <= 1'b0; sel <= 1'b0; oe <= 1'b0; rx_byte <= '0;
    end else if (!en) begin
      st <= ST_IDLE; oe <= 1'b0; sel <= 1'b0; ack_on <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; oe <= 1'b0; sel <= 1'b0; ack_on <= 1'b0;
    end else if (start_ev) begin
      st <= ST_ADDR; cnt <= '0; oe <= 1'b0; ack_on <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: if (scl_rise) begin
          sh  <= addr_byte;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (addr_hit(addr_byte, OWN_ADDR)) begin
              st <= ST_AACK; rw_q <= sda_s; sel <= 1'b1;
            end else begin
              st <= ST_IDLE; sel <= 1'b0;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          if (!ack_on) begin
            ack_on <= 1'b1; oe <= 1'b1;       // address ACK, FNA not used
          end else begin
            ack_on <= 1'b0; cnt <= '0;
            if (rw_q) begin
              st <= ST_TX; sh <= tx_byte; oe <= ~tx_byte[7];
            end else begin
              st <= ST_RX; oe <= 1'b0;
            end
          end
        end
        ST_RX: if (scl_rise) begin
          sh  <= addr_byte;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            rx_byte <= addr_byte; st <= ST_RACK; ack_on <= 1'b0;
          end
        end
        ST_RACK: if (scl_fall) begin
          if (!ack_on) begin
            ack_on <= 1'b1; oe <= ~fna;
          end else begin
            ack_on <= 1'b0; oe <= 1'b0; cnt <= '0; st <= ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == 3'd7) begin
            oe <= 1'b0; st <= ST_TACK; ack_on <= 1'b0;
          end else begin
            sh <= {sh[6:0], 1'b0}; oe <= ~sh[6]; cnt <= cnt + 3'd1;
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            if (sda_s) st <= ST_IDLE;
            else       ack_on <= 1'b1;
          end else if (scl_fall && ack_on) begin
            st <= ST_TX; sh <= tx_byte; oe <= ~tx_byte[7];
            cnt <= '0; ack_on <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2ct_status.sv
module i2ct_status
  import i2ct_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [NUM_STICKY-1:0] set_lo,
  input  logic                  gc_set,
  input  logic                  dir_load,
  input  logic                  dir_val,
  input  logic                  wr,
  input  logic [NUM_STICKY-1:0] wmask,
  output logic [7:0]            stat
);
  logic [NUM_STICKY-1:0] lo;
  logic gc, dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0; gc <= 1'b0; dir <= 1'b0;
    end else begin
      lo <= sticky_next(lo, set_lo, wr, wmask);
      if (!en || set_lo[FLG_STOP]) gc <= 1'b0;
      else if (gc_set)             gc <= 1'b1;
      if (!en)           dir <= 1'b0;
      else if (dir_load) dir <= dir_val;
    end
  end

  assign stat = {1'b0, gc, dir, lo};
endmodule

// File: rtl/i2c_target_stat.sv
module i2c_target_stat
  import i2ct_pkg::*;
#(
  parameter logic [6:0]  OWN_ADDR    = 7'h2A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam logic [1:0] RA_CTRL = 2'd0, RA_STAT = 2'd1, RA_IEN = 2'd2, RA_DATA = 2'd3;

  logic en, fna;
  logic [NUM_STICKY-1:0] ien;
  logic [7:0] tx_q, rx_byte, stat_q;
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic ev_match, ev_gcall, ev_rw, ev_rxdone, ev_txload, ev_nack, ev_stop;
  logic aack_drv, rack_drv;
  logic [NUM_STICKY-1:0] set_lo;
  logic wr_stat;

  i2ct_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2ct_engine #(.OWN_ADDR(OWN_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .fna(fna), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .tx_byte(tx_q), .sda_oe(sda_oe), .rx_byte(rx_byte),
    .ev_match(ev_match), .ev_gcall(ev_gcall), .ev_rw(ev_rw), .ev_rxdone(ev_rxdone),
    .ev_txload(ev_txload), .ev_nack(ev_nack), .ev_stop(ev_stop),
    .aack_drv(aack_drv), .rack_drv(rack_drv)
  );

  always_comb begin
    set_lo = '0;
    set_lo[FLG_ADDR] = ev_match;
    set_lo[FLG_RXD]  = ev_rxdone;
    set_lo[FLG_TXD]  = ev_txload;
    set_lo[FLG_NAK]  = ev_nack;
    set_lo[FLG_STOP] = ev_stop;
  end

  assign wr_stat = reg_we && reg_addr == RA_STAT;

  i2ct_status u_stat (
    .clk(clk), .rst_n(rst_n), .en(en), .set_lo(set_lo), .gc_set(ev_gcall),
    .dir_load(ev_match), .dir_val(ev_rw), .wr(wr_stat),
    .wmask(reg_wdata[NUM_STICKY-1:0]), .stat(stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; fna <= 1'b0; ien <= '0; tx_q <= '0;
    end else if (reg_we) begin
      unique case (reg_addr)
        RA_CTRL: begin fna <= reg_wdata[0]; en <= reg_wdata[1]; end
        RA_IEN:  ien  <= reg_wdata[NUM_STICKY-1:0];
        RA_DATA: tx_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = {6'b0, en, fna};
      RA_STAT: reg_rdata = stat_q;
      RA_IEN:  reg_rdata = {{(8-NUM_STICKY){1'b0}}, ien};
      default: reg_rdata = rx_byte;
    endcase
  end

  assign irq = irq_fold(stat_q[NUM_STICKY-1:0], ien);
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       fna,
  input logic       sda_oe,
  input logic [7:0] stat,
  input logic       irq,
  input logic       hit,
  input logic       aack_drv,
  input logic       rack_drv,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata
);
  assert_addr_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    aack_drv |-> sda_oe);

  assert_data_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rack_drv) |-> (sda_oe == !$past(fna)));

  for (genvar i = 0; i < 5; i++) begin : g_sticky
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat[i]) && !($past(reg_we) && $past(reg_addr) == 2'd1 && !$past(reg_wdata[i])))
      |-> stat[i]);
  end

  assert_gcall_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !stat[6]);

  assert_gcall_noirq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[4:0] == 5'd0) |-> !irq);

  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit) |=> $stable(stat[5]));

  assert_off_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_oe);
endmodule

bind i2c_target_stat i2ct_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fna(fna), .sda_oe(sda_oe), .stat(stat_q),
  .irq(irq), .hit(ev_match), .aack_drv(aack_drv), .rack_drv(rack_drv),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/i2c_target_stat_bench.sv
module i2c_target_stat_bench;
  localparam int Q = 6;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, irq;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic sda_line;
  int n_chk = 0, n_err = 0;
  logic [7:0] exp_stat;
  logic [4:0] exp_ien;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_target_stat #(.OWN_ADDR(OWN)) u_i2c_target_stat (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  // reference model for the interrupt line
  function automatic logic model_irq(input logic [7:0] s, input logic [4:0] e);
    for (int i = 0; i < 5; i++) if (s[i] && e[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk_stat(input string req);
    logic [7:0] v;
    rd(2'd1, v);
    chk(req, v, exp_stat);
    chk({req, " irq"}, {7'd0, irq}, {7'd0, model_irq(exp_stat, exp_ien)});
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(Q);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    s = sda_line; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(!mack, s);
  endtask

  initial begin
    logic [7:0] v;
    logic ak;
    waitc(4);
    rst_n = 1'b1;
    waitc(2);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register reset", v, 8'h00);
    end
    chk("R1 sda released", {7'd0, sda_oe}, 8'h00);
    chk("R1 irq low", {7'd0, irq}, 8'h00);

    exp_ien = 5'h1F;
    wr(2'd2, 8'h1F);
    wr(2'd0, 8'h02);            // enable, FNA=0
    exp_stat = 8'h00;

    // R2 own address write, R5 data with FNA 0 and 1
    bus_start;
    send_byte({OWN, 1'b0}, ak);
    chk("R2 address ack", {7'd0, ak}, 8'h01);
    exp_stat = 8'h01;
    chk_stat("R2 address flag");
    send_byte(8'hA5, ak);
    chk("R5 data ack fna=0", {7'd0, ak}, 8'h01);
    exp_stat = 8'h03;
    chk_stat("R5 rx flag");
    rd(2'd3, v);
    chk("R5 rx data", v, 8'hA5);
    wr(2'd0, 8'h03);            // FNA=1
    send_byte(8'h3C, ak);
    chk("R5 data nack fna=1", {7'd0, ak}, 8'h00);
    rd(2'd3, v);
    chk("R5 rx data 2", v, 8'h3C);
    bus_stop;
    exp_stat = 8'h13;
    chk_stat("R9 stop flag");

    // R10 write ones keeps, write zeros clears
    wr(2'd1, 8'hFF);
    chk_stat("R10 write ones");
    wr(2'd1, 8'h00);
    exp_stat = 8'h00;
    chk_stat("R10 write zeros");

    // R6 FNA still 1, address still acked
    bus_start;
    send_byte({OWN, 1'b0}, ak);
    chk("R6 address ack with fna=1", {7'd0, ak}, 8'h01);
    bus_stop;
    exp_stat = 8'h11;
    chk_stat("R6 flags");
    wr(2'd1, 8'h00);
    exp_stat = 8'h00;

    // R3 foreign address
    bus_start;
    send_byte(8'h50, ak);
    chk("R3 foreign address nack", {7'd0, ak}, 8'h00);
    bus_stop;
    chk_stat("R3 no flags");

    // R4 general call
    wr(2'd0, 8'h02);
    bus_start;
    send_byte(8'h00, ak);
    chk("R4 general call ack", {7'd0, ak}, 8'h01);
    exp_stat = 8'h41;
    chk_stat("R4 general call flags");
    wr(2'd1, 8'hFE);
    exp_stat = 8'h40;
    chk_stat("R4 general call alone no irq");
    bus_stop;
    exp_stat = 8'h10;
    chk_stat("R9 stop clears general call");
    wr(2'd1, 8'h00);

    // R9 disable clears general call
    bus_start;
    send_byte(8'h00, ak);
    wr(2'd0, 8'h00);
    exp_stat = 8'h01;
    chk_stat("R9 disable clears general call");
    bus_stop;
    chk_stat("R12 stop while disabled");
    wr(2'd1, 8'h00);
    exp_stat = 8'h00;

    // R12 disabled ignores bus
    bus_start;
    send_byte({OWN, 1'b0}, ak);
    chk("R12 no ack when disabled", {7'd0, ak}, 8'h00);
    bus_stop;
    chk_stat("R12 no flags when disabled");

    // R7 read transfer, R8 master nack
    wr(2'd0, 8'h02);
    wr(2'd3, 8'hC3);
    bus_start;
    send_byte({OWN, 1'b1}, ak);
    chk("R7 read address ack", {7'd0, ak}, 8'h01);
    exp_stat = 8'h25;
    chk_stat("R7 direction and tx flags");
    wr(2'd3, 8'h5A);
    recv_byte(1'b1, v);
    chk("R7 first byte", v, 8'hC3);
    recv_byte(1'b0, v);
    chk("R7 second byte", v, 8'h5A);
    exp_stat = 8'h2D;
    chk_stat("R8 nack flag");
    chk("R8 sda released", {7'd0, sda_oe}, 8'h00);
    bus_stop;
    exp_stat = 8'h3D;
    chk_stat("R9 stop after read");
    wr(2'd1, 8'h00);
    exp_stat = 8'h20;
    chk_stat("R10 direction ignores writes");
    wr(2'd1, 8'hFF);
    chk_stat("R10 bit7 reads zero");

    // R11 interrupt masking
    exp_ien = 5'h02;
    wr(2'd2, 8'h02);
    bus_start;
    send_byte({OWN, 1'b0}, ak);
    bus_stop;
    exp_stat = 8'h11;
    chk_stat("R11 masked flags");
    exp_ien = 5'h10;
    wr(2'd2, 8'h10);
    chk_stat("R11 enabled stop flag");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule